// File: doc/BRIEF.md
# Accumulator and Link-Bit Datapath

This block keeps a processor's single working register (a 16-bit accumulator) and a one-bit link flag beside it, together with the arithmetic and logic circuit that updates both. The control unit sends one strobe per operation. The operand comes from the data register, and a byte comes from the input buffer. The block applies the selected operation at the next clock edge.

The operations are bitwise AND and two's-complement addition, with the carry-out kept in the link. The accumulator can also be loaded from the operand, or have its low byte replaced by the input byte. It can be complemented, cleared or incremented. Circular shifts run through the link, so the accumulator and the link form a 17-bit ring. The link can be cleared or inverted on its own.

Four registered-state flags tell the control unit whether to skip the next instruction: accumulator positive, negative, zero, and link zero. When several strobes arrive in the same cycle, a fixed priority decides which one takes effect.

Top module: `acc_link_dp`

## Requirements
- R1: After reset (rst_n low), the accumulator and the link both read 0.
- R2: With op_and, the accumulator becomes the bitwise AND of itself and dr_i, and the link is kept.
- R3: With op_add, the accumulator becomes the low 16 bits of accumulator plus dr_i, and the link takes the carry out of bit 15 (0 when there is no carry).
- R4: With op_xfer, the accumulator becomes dr_i. With op_inp, bits 7:0 become in_byte_i and bits 15:8 are kept. The link is kept in both cases.
- R5: op_cla clears the accumulator. op_cma inverts every bit. op_inc adds one, wrapping 0xFFFF to 0x0000, and leaves the link unchanged.
- R6: op_cle clears the link and op_cme inverts it. Neither one changes the accumulator.
- R7: op_cir moves the accumulator right by one bit. The old link goes into bit 15 and the old bit 0 goes into the link. op_cil moves it left by one bit. The old link goes into bit 0 and the old bit 15 goes into the link.
- R8: The skip flags come from the registered state. skip_pos_o is 1 when bit 15 is 0. skip_neg_o is 1 when bit 15 is 1. skip_zero_o is 1 when the accumulator is all zeros. skip_lz_o is 1 when the link is 0.
- R9: When strobes coincide, the accumulator takes, in this order: clear (op_cla); then one load, chosen in the order and, add, xfer, inp, cma, cir, cil; then increment. The link takes, in this order: op_cle; then the link value of the winning add or shift load; then op_cme.
- R10: In a cycle with no strobe, the accumulator and the link keep their values whatever dr_i and in_byte_i are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dr_i | input | 16 | Operand from the data register |
| in_byte_i | input | 8 | Byte from the input buffer |
| op_and | input | 1 | AND strobe |
| op_add | input | 1 | Add strobe |
| op_xfer | input | 1 | Load operand strobe |
| op_inp | input | 1 | Load input byte strobe |
| op_cma | input | 1 | Complement accumulator strobe |
| op_cir | input | 1 | Rotate right through link strobe |
| op_cil | input | 1 | Rotate left through link strobe |
| op_cla | input | 1 | Clear accumulator strobe |
| op_inc | input | 1 | Increment accumulator strobe |
| op_cle | input | 1 | Clear link strobe |
| op_cme | input | 1 | Complement link strobe |
| acc_o | output | 16 | Accumulator |
| link_o | output | 1 | Link flag |
| skip_pos_o | output | 1 | Accumulator sign bit is 0 |
| skip_neg_o | output | 1 | Accumulator sign bit is 1 |
| skip_zero_o | output | 1 | Accumulator is zero |
| skip_lz_o | output | 1 | Link is 0 |

## Verification
Two functions can collide in one cycle: an accumulator update and a link update. Examples are an add whose carry competes with a link complement, or an accumulator clear that competes with a load. The bench raises these strobes in the same cycle. It judges each accumulator and link against the priority order of R9, worked out by hand. The cases include the and-over-add case, where the link must keep its earlier value because the add loses.

// File: rtl/acc_pkg.sv
package acc_pkg;
    // Which load-class result the accumulator takes.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_AND,
        SEL_ADD,
        SEL_XFER,
        SEL_INP,
        SEL_CMA,
        SEL_CIR,
        SEL_CIL
    } load_sel_e;

    // What happens to the link flag.
    typedef enum logic [1:0] {
        LK_HOLD,
        LK_CLR,
        LK_LOAD,
        LK_INV
    } link_act_e;
endpackage

// File: rtl/acc_prio.sv
module acc_prio
    import acc_pkg::*;
(
    input  logic      op_and,
    input  logic      op_add,
    input  logic      op_xfer,
    input  logic      op_inp,
    input  logic      op_cma,
    input  logic      op_cir,
    input  logic      op_cil,
    input  logic      op_cla,
    input  logic      op_inc,
    input  logic      op_cle,
    input  logic      op_cme,
    output logic      clr_acc,
    output load_sel_e load_sel,
    output logic      inc_acc,
    output link_act_e link_act
);
    logic any_load;
    logic load_drives_link;

    always_comb begin
        // Load order: and, add, xfer, inp, cma, cir, cil.
        if      (op_and)  load_sel = SEL_AND;
        else if (op_add)  load_sel = SEL_ADD;
        else if (op_xfer) load_sel = SEL_XFER;
        else if (op_inp)  load_sel = SEL_INP;
        else if (op_cma)  load_sel = SEL_CMA;
        else if (op_cir)  load_sel = SEL_CIR;
        else if (op_cil)  load_sel = SEL_CIL;
        else              load_sel = SEL_NONE;

        any_load = (load_sel != SEL_NONE);
        clr_acc  = op_cla;
        inc_acc  = op_inc && !op_cla && !any_load;

        // The link follows a winning add or shift only when the
        // accumulator is not being cleared.
        load_drives_link = !op_cla &&
                           ((load_sel == SEL_ADD) ||
                            (load_sel == SEL_CIR) ||
                            (load_sel == SEL_CIL));

        if      (op_cle)           link_act = LK_CLR;
        else if (load_drives_link) link_act = LK_LOAD;
        else if (op_cme)           link_act = LK_INV;
        else                       link_act = LK_HOLD;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W    = 16,
    parameter int IN_W = 8
) (
    input  logic [W-1:0]    acc,
    input  logic            link,
    input  logic [W-1:0]    dr,
    input  logic [IN_W-1:0] in_byte,
    input  load_sel_e       sel,
    output logic [W-1:0]    res,
    output logic            link_res
);
    logic [W:0] sum;

    always_comb begin
        sum      = {1'b0, acc} + {1'b0, dr};
        res      = acc;
        link_res = link;
        unique case (sel)
            SEL_AND:  res = acc & dr;
            SEL_ADD:  begin
                res      = sum[W-1:0];
                link_res = sum[W];
            end
            SEL_XFER: res = dr;
            SEL_INP:  res = {acc[W-1:IN_W], in_byte};
            SEL_CMA:  res = ~acc;
            SEL_CIR:  begin
                res      = {link, acc[W-1:1]};
                link_res = acc[0];
            end
            SEL_CIL:  begin
                res      = {acc[W-2:0], link};
                link_res = acc[W-1];
            end
            default:  res = acc;
        endcase
    end
endmodule

// File: rtl/acc_skip.sv
module acc_skip #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic         link,
    output logic         pos,
    output logic         neg,
    output logic         zero,
    output logic         lz
);
    always_comb begin
        neg  = acc[W-1];
        pos  = !acc[W-1];
        zero = (acc == '0);
        lz   = !link;
    end
endmodule

// File: rtl/acc_link_dp.sv
module acc_link_dp
    import acc_pkg::*;
#(
    parameter int W    = 16,
    parameter int IN_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    dr_i,
    input  logic [IN_W-1:0] in_byte_i,
    input  logic            op_and,
    input  logic            op_add,
    input  logic            op_xfer,
    input  logic            op_inp,
    input  logic            op_cma,
    input  logic            op_cir,
    input  logic            op_cil,
    input  logic            op_cla,
    input  logic            op_inc,
    input  logic            op_cle,
    input  logic            op_cme,
    output logic [W-1:0]    acc_o,
    output logic            link_o,
    output logic            skip_pos_o,
    output logic            skip_neg_o,
    output logic            skip_zero_o,
    output logic            skip_lz_o
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         link;
    } state_t;

    state_t    st_d, st_q;
    logic      clr_acc, inc_acc;
    load_sel_e load_sel;
    link_act_e link_act;
    logic [W-1:0] alu_res;
    logic         alu_link;

    acc_prio u_prio (
        .op_and  (op_and),
        .op_add  (op_add),
        .op_xfer (op_xfer),
        .op_inp  (op_inp),
        .op_cma  (op_cma),
        .op_cir  (op_cir),
        .op_cil  (op_cil),
        .op_cla  (op_cla),
        .op_inc  (op_inc),
        .op_cle  (op_cle),
        .op_cme  (op_cme),
        .clr_acc (clr_acc),
        .load_sel(load_sel),
        .inc_acc (inc_acc),
        .link_act(link_act)
    );

    acc_alu #(.W(W), .IN_W(IN_W)) u_alu (
        .acc     (st_q.acc),
        .link    (st_q.link),
        .dr      (dr_i),
        .in_byte (in_byte_i),
        .sel     (load_sel),
        .res     (alu_res),
        .link_res(alu_link)
    );

    acc_skip #(.W(W)) u_skip (
        .acc (st_q.acc),
        .link(st_q.link),
        .pos (skip_pos_o),
        .neg (skip_neg_o),
        .zero(skip_zero_o),
        .lz  (skip_lz_o)
    );

    always_comb begin
        st_d = st_q;
        if (clr_acc)                    st_d.acc = '0;
        else if (load_sel != SEL_NONE)  st_d.acc = alu_res;
        else if (inc_acc)               st_d.acc = st_q.acc + 1'b1;

        unique case (link_act)
            LK_CLR:  st_d.link = 1'b0;
            LK_LOAD: st_d.link = alu_link;
            LK_INV:  st_d.link = ~st_q.link;
            default: st_d.link = st_q.link;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign link_o = st_q.link;
endmodule

// File: rtl/acc_link_chk.sv
module acc_link_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_and,
    input logic         op_add,
    input logic         op_xfer,
    input logic         op_inp,
    input logic         op_cma,
    input logic         op_cir,
    input logic         op_cil,
    input logic         op_cla,
    input logic         op_inc,
    input logic         op_cle,
    input logic         op_cme,
    input logic [W-1:0] acc_o,
    input logic         link_o,
    input logic         skip_pos_o,
    input logic         skip_neg_o
);
    logic any_op;
    assign any_op = op_and | op_add | op_xfer | op_inp | op_cma | op_cir |
                    op_cil | op_cla | op_inc | op_cle | op_cme;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        op_cla |=> (acc_o == '0)); // R9

    AST_LINK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        op_cle |=> !link_o); // R6

    AST_INC_KEEPS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_inc && !op_cle && !op_cme && !op_add && !op_cir && !op_cil)
        |=> (link_o == $past(link_o))); // R5

    AST_INP_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_inp && !op_cla && !op_and && !op_add && !op_xfer)
        |=> (acc_o[W-1:8] == $past(acc_o[W-1:8]))); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !any_op |=> ($stable(acc_o) && $stable(link_o))); // R10

    AST_SIGN_SKIPS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        skip_pos_o != skip_neg_o); // R8
endmodule

bind acc_link_dp acc_link_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_and    (op_and),
    .op_add    (op_add),
    .op_xfer   (op_xfer),
    .op_inp    (op_inp),
    .op_cma    (op_cma),
    .op_cir    (op_cir),
    .op_cil    (op_cil),
    .op_cla    (op_cla),
    .op_inc    (op_inc),
    .op_cle    (op_cle),
    .op_cme    (op_cme),
    .acc_o     (acc_o),
    .link_o    (link_o),
    .skip_pos_o(skip_pos_o),
    .skip_neg_o(skip_neg_o)
);

// File: tb/tb_acc_link_dp.sv
module tb_acc_link_dp;
    // Strobe bit positions used by the bench helper only.
    localparam logic [10:0] K_AND  = 11'd1 << 0;
    localparam logic [10:0] K_ADD  = 11'd1 << 1;
    localparam logic [10:0] K_XFER = 11'd1 << 2;
    localparam logic [10:0] K_INP  = 11'd1 << 3;
    localparam logic [10:0] K_CMA  = 11'd1 << 4;
    localparam logic [10:0] K_CIR  = 11'd1 << 5;
    localparam logic [10:0] K_CIL  = 11'd1 << 6;
    localparam logic [10:0] K_CLA  = 11'd1 << 7;
    localparam logic [10:0] K_INC  = 11'd1 << 8;
    localparam logic [10:0] K_CLE  = 11'd1 << 9;
    localparam logic [10:0] K_CME  = 11'd1 << 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dr_i = '0;
    logic [7:0]  in_byte_i = '0;
    logic [10:0] ops = '0;
    logic [15:0] acc_o;
    logic        link_o, skip_pos_o, skip_neg_o, skip_zero_o, skip_lz_o;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    acc_link_dp dut (
        .clk(clk), .rst_n(rst_n), .dr_i(dr_i), .in_byte_i(in_byte_i),
        .op_and(ops[0]), .op_add(ops[1]), .op_xfer(ops[2]), .op_inp(ops[3]),
        .op_cma(ops[4]), .op_cir(ops[5]), .op_cil(ops[6]), .op_cla(ops[7]),
        .op_inc(ops[8]), .op_cle(ops[9]), .op_cme(ops[10]),
        .acc_o(acc_o), .link_o(link_o), .skip_pos_o(skip_pos_o),
        .skip_neg_o(skip_neg_o), .skip_zero_o(skip_zero_o), .skip_lz_o(skip_lz_o)
    );

    task automatic chk(input string req, input logic [15:0] acc_e, input logic link_e);
        n_chk++;
        if (acc_o !== acc_e || link_o !== link_e) begin
            n_bad++;
            $display("FAIL %s: acc=%h link=%b expected acc=%h link=%b",
                     req, acc_o, link_o, acc_e, link_e);
        end
    endtask

    task automatic chk_skip(input string req, input logic [3:0] exp_f);
        n_chk++;
        if ({skip_pos_o, skip_neg_o, skip_zero_o, skip_lz_o} !== exp_f) begin
            n_bad++;
            $display("FAIL %s: skips=%b expected %b", req,
                     {skip_pos_o, skip_neg_o, skip_zero_o, skip_lz_o}, exp_f);
        end
    endtask

    // Drive strobes for one clock; results are visible at the next falling edge.
    task automatic step(input logic [10:0] k, input logic [15:0] d, input logic [7:0] b);
        @(negedge clk);
        ops = k; dr_i = d; in_byte_i = b;
        @(negedge clk);
        ops = '0;
    endtask

    task automatic set_state(input logic [15:0] a, input logic l);
        step(K_XFER | K_CLE, a, 8'h00);
        if (l) step(K_CME, 16'h0, 8'h00);
    endtask

    task automatic t_reset;
        chk("R1 reset", 16'h0000, 1'b0);
        chk_skip("R8 reset skips", 4'b1011);
    endtask

    task automatic t_logic_load;
        step(K_XFER, 16'h1234, 8'h00); chk("R4 xfer", 16'h1234, 1'b0);
        step(K_AND, 16'h0FF0, 8'h00);  chk("R2 and", 16'h0230, 1'b0);
        set_state(16'hAB00, 1'b1);
        step(K_INP, 16'hFFFF, 8'h5C);  chk("R4 inp keeps upper", 16'hAB5C, 1'b1);
    endtask

    task automatic t_add;
        set_state(16'hFFFF, 1'b0);
        step(K_ADD, 16'h0001, 8'h00);  chk("R3 add carry", 16'h0000, 1'b1);
        step(K_XFER, 16'h0001, 8'h00);
        step(K_ADD, 16'h0002, 8'h00);  chk("R3 add no carry", 16'h0003, 1'b0);
    endtask

    task automatic t_unary;
        set_state(16'hAB5C, 1'b0);
        step(K_CMA, 16'h0, 8'h00);     chk("R5 cma", 16'h54A3, 1'b0);
        step(K_CLA, 16'h0, 8'h00);     chk("R5 cla", 16'h0000, 1'b0);
        set_state(16'hFFFF, 1'b1);
        step(K_INC, 16'h0, 8'h00);     chk("R5 inc wrap keeps link", 16'h0000, 1'b1);
        step(K_CME, 16'h0, 8'h00);     chk("R6 cme", 16'h0000, 1'b0);
        step(K_CME, 16'h0, 8'h00);
        step(K_CLE, 16'h0, 8'h00);     chk("R6 cle", 16'h0000, 1'b0);
    endtask

    task automatic t_rotate;
        set_state(16'h0001, 1'b0);
        step(K_CIR, 16'h0, 8'h00);     chk("R7 cir out", 16'h0000, 1'b1);
        step(K_CIR, 16'h0, 8'h00);     chk("R7 cir in", 16'h8000, 1'b0);
        step(K_CIL, 16'h0, 8'h00);     chk("R7 cil out", 16'h0000, 1'b1);
        step(K_CIL, 16'h0, 8'h00);     chk("R7 cil in", 16'h0001, 1'b0);
    endtask

    task automatic t_skip;
        set_state(16'h8000, 1'b1);
        chk_skip("R8 negative link set", 4'b0100);
        set_state(16'h0042, 1'b0);
        chk_skip("R8 positive link clear", 4'b1001);
    endtask

    task automatic t_priority;
        set_state(16'h1111, 1'b0);
        step(K_CLA | K_XFER, 16'h7777, 8'h00); chk("R9 clear over load", 16'h0000, 1'b0);
        step(K_XFER | K_INC, 16'h0005, 8'h00); chk("R9 load over inc", 16'h0005, 1'b0);
        set_state(16'h00F0, 1'b1);
        step(K_AND | K_ADD, 16'h0F0F, 8'h00);  chk("R9 and over add", 16'h0000, 1'b1);
        step(K_CLE | K_CME, 16'h0, 8'h00);     chk("R9 cle over cme", 16'h0000, 1'b0);
        set_state(16'h0001, 1'b0);
        step(K_ADD | K_CME, 16'h0001, 8'h00);  chk("R9 add carry over cme", 16'h0002, 1'b0);
        step(K_CLA | K_ADD | K_CME, 16'hFFFF, 8'h00); chk("R9 cla blocks carry", 16'h0000, 1'b1);
    endtask

    task automatic t_idle;
        set_state(16'hC3C3, 1'b1);
        step('0, 16'h0000, 8'hFF);     chk("R10 idle hold", 16'hC3C3, 1'b1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset;
                t_logic_load;
                t_add;
                t_unary;
                t_rotate;
                t_skip;
                t_priority;
                t_idle;
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule